// File: doc/BRIEF.md
# Alarm Timer and Interrupt Controller

This block sits beside a set of calendar counters and watches them. It compares the current hundredths, seconds, minutes, hours, date and month values with a set of programmable alarm bytes. It also runs a two-digit BCD timer that steps at a resolution picked by an alarm control byte. It owns two sticky status flags: the timer flag, which a timer wrap sets, and the alarm flag, which a calendar match or a timer match sets. From these flags it drives an active-low, open-drain interrupt. That pin is modelled as a drive-low enable.

An enable input chooses between two behaviours. When the enable is high, the alarm control byte governs the timer, the matches and the interrupt masks. When the enable is low, the control byte is ignored and the timer stops. The two status bits then show free-running square waves taken from the counters: one with a one-second period and one with a one-minute period. The interrupt pin carries the one-second wave, which can be used for calibration.

The counters and their tick strobes are inputs. Each tick is a one-cycle pulse given in the cycle in which the counter inputs already show the new value. Host writes to the flags and to the timer arrive as single-cycle write strobes.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the timer reads 00, both flags are 0, both square-wave states are 0 and the interrupt drive is inactive.
- R2: Daily alarm (control bits 5:4 = 01): the hundredths, seconds, minutes and hours counters must equal their alarm bytes bit for bit. The alarm flag sets at the clock edge that ends the cycle in which `tick_hsec` is high.
- R3: The timer advances by one BCD step on each tick picked by control bits 2:0: 001 hundredths, 010 seconds, 011 minutes, 100 hours, 101 days, and 111 every clock cycle. Codes 000 and 110 hold the timer. A timer write loads the value and takes priority over a step.
- R4: A step from 99 gives 00, with no carry onward. The timer flag (status bit 0) sets on the same edge.
- R5: When control bit 6 is 1, the alarm flag (status bit 1) sets one edge after the timer first shows a value equal to `alm_timer`.
- R6: Each flag holds its value until a flag write. A flag write loads bit 0 into the timer flag and bit 1 into the alarm flag. A set event in the same cycle wins over the write.
- R7: The interrupt drive is high when either the alarm flag is set with control bit 7 = 1, or the timer flag is set with control bit 3 = 1. It changes on the same edge as the flags.
- R8: Weekday alarm (bits 5:4 = 10): the time fields match as in R2, and the mask bit in `alm_wdmon` chosen by the current weekday (`cnt_wdmon[7:5]`, 0 to 6) must be 1. Mask bit 7 and weekday value 7 never fire.
- R9: Dated alarm (bits 5:4 = 11): the date (`[5:0]` of the year/date byte) and the month (`[4:0]` of the weekday/month byte) must also match. The year bits `[7:6]` and the weekday bits `[7:5]` are ignored.
- R10: A flag is set only on the evaluation where equality first appears. An equality that persists does not set the flag again after the host has cleared it. An equality already present at reset does not fire.
- R11: With `alarm_en` = 0, the control byte is ignored, the timer holds and no flag is set. Status bit 0 shows 1 while the hundredths counter is 50 or more, and status bit 1 shows 1 while the seconds counter is 30 or more. Both are sampled on `tick_hsec`. The interrupt drive follows status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alarm_en | input | 1 | Alarm function enable (status byte bit 2) |
| alarm_ctl | input | 8 | Alarm control byte |
| tick_hsec | input | 1 | Hundredths counter changed this cycle |
| tick_sec | input | 1 | Seconds counter changed this cycle |
| tick_min | input | 1 | Minutes counter changed this cycle |
| tick_hour | input | 1 | Hours counter changed this cycle |
| tick_day | input | 1 | Day counter changed this cycle |
| cnt_hsec | input | 8 | Current hundredths, BCD |
| cnt_sec | input | 8 | Current seconds, BCD |
| cnt_min | input | 8 | Current minutes, BCD |
| cnt_hour | input | 8 | Current hours byte |
| cnt_ydate | input | 8 | Year [7:6], date [5:0] |
| cnt_wdmon | input | 8 | Weekday [7:5], month [4:0] |
| alm_hsec | input | 8 | Alarm hundredths |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours |
| alm_ydate | input | 8 | Alarm date in [5:0] |
| alm_wdmon | input | 8 | Alarm month [4:0] or weekday mask [6:0] |
| alm_timer | input | 8 | Alarm timer compare value |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: [0] timer flag, [1] alarm flag |
| timer_wr | input | 1 | Timer write strobe |
| timer_wdata | input | 8 | Timer load value |
| stat_flags | output | 2 | Status bits: [0] timer flag or seconds wave, [1] alarm flag or minutes wave |
| timer_val | output | 8 | Current timer value |
| irq_drive_low | output | 1 | Pull the interrupt line low when 1 |

## Verification
The in-line properties check several behaviours on every cycle:
- both flags stay set without a write;
- an increment from 99 lands on 00;
- the timer holds when it is neither stepping nor being loaded;
- the interrupt stays inactive while both of its masks are clear;
- a disabled alarm function never sets the alarm flag.

Other behaviours depend on particular counter values, so only the bench's scenarios can show them:
- the field masking that separates daily, weekday and dated matches;
- the first-equality rule for a held match;
- the one-edge delay of the timer match;
- the thresholds of the square waves.

A reference model in the bench follows every cycle of the mixed random and directed traffic.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    typedef enum logic [2:0] {
        RES_NONE  = 3'b000,
        RES_HSEC  = 3'b001,
        RES_SEC   = 3'b010,
        RES_MIN   = 3'b011,
        RES_HOUR  = 3'b100,
        RES_DAY   = 3'b101,
        RES_SPARE = 3'b110,
        RES_TEST  = 3'b111
    } tmr_res_e;

    typedef enum logic [1:0] {
        CAL_OFF     = 2'b00,
        CAL_DAILY   = 2'b01,
        CAL_WEEKDAY = 2'b10,
        CAL_DATED   = 2'b11
    } cal_mode_e;

    // Bit order matches the control byte: [7] down to [0]
    typedef struct packed {
        logic      irq_alarm;
        logic      tmr_alarm;
        cal_mode_e cal;
        logic      irq_timer;
        tmr_res_e  res;
    } alm_ctl_t;

    // One BCD count step on a two-digit byte (the caller handles 99)
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [3:0] hi;
        hi = v[7:4] + 4'd1;
        if (v[3:0] >= 4'd9) return {hi, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/alm_cal_match.sv
module alm_cal_match
    import rtc_alm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WDAY_N = 7,
    parameter int DATE_W = 6,
    parameter int MON_W  = 5
) (
    input  cal_mode_e         mode,
    input  logic [BYTE_W-1:0] cnt_hsec,
    input  logic [BYTE_W-1:0] cnt_sec,
    input  logic [BYTE_W-1:0] cnt_min,
    input  logic [BYTE_W-1:0] cnt_hour,
    input  logic [BYTE_W-1:0] cnt_ydate,
    input  logic [BYTE_W-1:0] cnt_wdmon,
    input  logic [BYTE_W-1:0] alm_hsec,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hour,
    input  logic [BYTE_W-1:0] alm_ydate,
    input  logic [BYTE_W-1:0] alm_wdmon,
    output logic              hit
);
    localparam int WD_W = BYTE_W - MON_W;

    logic [WD_W-1:0]   cur_wday;
    logic [WDAY_N-1:0] wday_sel;
    logic              time_eq, date_eq, mon_eq, wday_ok;
    logic              unused_fields;

    assign cur_wday = cnt_wdmon[BYTE_W-1:MON_W];

    // One mask bit per weekday: fires only for the decoded current day
    for (genvar g = 0; g < WDAY_N; g++) begin : g_wday
        assign wday_sel[g] = (cur_wday == WD_W'(g)) && alm_wdmon[g];
    end

    always_comb begin
        time_eq = (cnt_hsec == alm_hsec) && (cnt_sec == alm_sec) &&
                  (cnt_min == alm_min) && (cnt_hour == alm_hour);
        date_eq = (cnt_ydate[DATE_W-1:0] == alm_ydate[DATE_W-1:0]);
        mon_eq  = (cnt_wdmon[MON_W-1:0] == alm_wdmon[MON_W-1:0]);
        wday_ok = |wday_sel;
        unique case (mode)
            CAL_DAILY:   hit = time_eq;
            CAL_WEEKDAY: hit = time_eq && wday_ok;
            CAL_DATED:   hit = time_eq && date_eq && mon_eq;
            default:     hit = 1'b0;
        endcase
    end

    assign unused_fields = ^{cnt_ydate[BYTE_W-1:DATE_W], alm_ydate[BYTE_W-1:DATE_W],
                             alm_wdmon[BYTE_W-1:WDAY_N]};

endmodule

// File: rtl/alm_tick_timer.sv
module alm_tick_timer
    import rtc_alm_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [7:0]  TOP_BCD = 8'h99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  tmr_res_e          res,
    input  logic              tick_hsec,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hour,
    input  logic              tick_day,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] count,
    output logic              wrap
);
    typedef struct packed {
        logic [BYTE_W-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        unique case (res)
            RES_HSEC: adv = tick_hsec;
            RES_SEC:  adv = tick_sec;
            RES_MIN:  adv = tick_min;
            RES_HOUR: adv = tick_hour;
            RES_DAY:  adv = tick_day;
            RES_TEST: adv = 1'b1;
            default:  adv = 1'b0;
        endcase
        adv = adv && run;
        if (wr) begin
            st_d.count = wdata;
        end else if (adv) begin
            if (st_q.count == BYTE_W'(TOP_BCD)) begin
                st_d.count = '0;
                wrap       = 1'b1;
            end else begin
                st_d.count = bcd_step(st_q.count);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && st_q.count == BYTE_W'(TOP_BCD)) |=> (st_q.count == '0));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr) |=> $stable(st_q.count));

    assert_stopped_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr) |=> $stable(st_q.count));

endmodule

// File: rtl/alm_flag_irq.sv
module alm_flag_irq
    import rtc_alm_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter logic [7:0] HALF_HS  = 8'h50,
    parameter logic [7:0] HALF_SEC = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_en,
    input  alm_ctl_t          ctl,
    input  logic              tick_hsec,
    input  logic              cal_hit,
    input  logic [BYTE_W-1:0] timer_val,
    input  logic [BYTE_W-1:0] alm_timer,
    input  logic              wrap,
    input  logic [BYTE_W-1:0] cnt_hsec,
    input  logic [BYTE_W-1:0] cnt_sec,
    input  logic              flag_wr,
    input  logic [1:0]        flag_wdata,
    output logic              tflag,
    output logic              aflag,
    output logic              wave_sec,
    output logic              wave_min,
    output logic              irq
);
    typedef struct packed {
        logic tflag;
        logic aflag;
        logic wave_sec;
        logic wave_min;
        logic cal_prev;
        logic tmr_prev;
        logic irq;
    } flg_state_t;

    localparam flg_state_t RST_VAL = '{tflag: 1'b0, aflag: 1'b0, wave_sec: 1'b0,
                                       wave_min: 1'b0, cal_prev: 1'b1, tmr_prev: 1'b1,
                                       irq: 1'b0};

    flg_state_t st_d, st_q;
    logic       cal_now, tmr_eq, set_cal, set_tmr;

    always_comb begin
        st_d    = st_q;
        cal_now = alarm_en && cal_hit;
        tmr_eq  = (timer_val == alm_timer);
        set_tmr = alarm_en && ctl.tmr_alarm && tmr_eq && !st_q.tmr_prev;
        set_cal = 1'b0;
        st_d.tmr_prev = tmr_eq;
        if (tick_hsec) begin
            set_cal        = cal_now && !st_q.cal_prev;
            st_d.cal_prev  = cal_now;
            st_d.wave_sec  = (cnt_hsec >= BYTE_W'(HALF_HS));
            st_d.wave_min  = (cnt_sec >= BYTE_W'(HALF_SEC));
        end
        if (flag_wr) begin
            st_d.tflag = flag_wdata[0];
            st_d.aflag = flag_wdata[1];
        end
        if (alarm_en && wrap)       st_d.tflag = 1'b1;
        if (set_cal || set_tmr)     st_d.aflag = 1'b1;
        if (alarm_en)
            st_d.irq = (st_d.aflag && ctl.irq_alarm) || (st_d.tflag && ctl.irq_timer);
        else
            st_d.irq = st_d.wave_sec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign tflag    = st_q.tflag;
    assign aflag    = st_q.aflag;
    assign wave_sec = st_q.wave_sec;
    assign wave_min = st_q.wave_min;
    assign irq      = st_q.irq;

    assert_tflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tflag && !flag_wr) |=> st_q.tflag);

    assert_aflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.aflag && !flag_wr) |=> st_q.aflag);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !ctl.irq_alarm && !ctl.irq_timer) |=> !st_q.irq);

    assert_no_set_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && !flag_wr && !st_q.aflag) |=> !st_q.aflag);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_en,
    input  logic [7:0]        alarm_ctl,
    input  logic              tick_hsec,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hour,
    input  logic              tick_day,
    input  logic [BYTE_W-1:0] cnt_hsec,
    input  logic [BYTE_W-1:0] cnt_sec,
    input  logic [BYTE_W-1:0] cnt_min,
    input  logic [BYTE_W-1:0] cnt_hour,
    input  logic [BYTE_W-1:0] cnt_ydate,
    input  logic [BYTE_W-1:0] cnt_wdmon,
    input  logic [BYTE_W-1:0] alm_hsec,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hour,
    input  logic [BYTE_W-1:0] alm_ydate,
    input  logic [BYTE_W-1:0] alm_wdmon,
    input  logic [BYTE_W-1:0] alm_timer,
    input  logic              flag_wr,
    input  logic [1:0]        flag_wdata,
    input  logic              timer_wr,
    input  logic [BYTE_W-1:0] timer_wdata,
    output logic [1:0]        stat_flags,
    output logic [BYTE_W-1:0] timer_val,
    output logic              irq_drive_low
);
    alm_ctl_t ctl;
    logic     cal_hit, wrap, tflag, aflag, wave_sec, wave_min;

    assign ctl = alm_ctl_t'(alarm_ctl);

    alm_cal_match #(.BYTE_W(BYTE_W)) u_match (
        .mode      (ctl.cal),
        .cnt_hsec  (cnt_hsec),
        .cnt_sec   (cnt_sec),
        .cnt_min   (cnt_min),
        .cnt_hour  (cnt_hour),
        .cnt_ydate (cnt_ydate),
        .cnt_wdmon (cnt_wdmon),
        .alm_hsec  (alm_hsec),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour),
        .alm_ydate (alm_ydate),
        .alm_wdmon (alm_wdmon),
        .hit       (cal_hit)
    );

    alm_tick_timer #(.BYTE_W(BYTE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (alarm_en),
        .res       (ctl.res),
        .tick_hsec (tick_hsec),
        .tick_sec  (tick_sec),
        .tick_min  (tick_min),
        .tick_hour (tick_hour),
        .tick_day  (tick_day),
        .wr        (timer_wr),
        .wdata     (timer_wdata),
        .count     (timer_val),
        .wrap      (wrap)
    );

    alm_flag_irq #(.BYTE_W(BYTE_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_en   (alarm_en),
        .ctl        (ctl),
        .tick_hsec  (tick_hsec),
        .cal_hit    (cal_hit),
        .timer_val  (timer_val),
        .alm_timer  (alm_timer),
        .wrap       (wrap),
        .cnt_hsec   (cnt_hsec),
        .cnt_sec    (cnt_sec),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .tflag      (tflag),
        .aflag      (aflag),
        .wave_sec   (wave_sec),
        .wave_min   (wave_min),
        .irq        (irq_drive_low)
    );

    // Status view: sticky flags when enabled, square waves otherwise (R11)
    assign stat_flags = alarm_en ? {aflag, tflag} : {wave_min, wave_sec};

endmodule

// File: tb/rtc_alarm_unit_bench.sv
module rtc_alarm_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alarm_en = 1'b0;
    logic [7:0] alarm_ctl = '0;
    logic tick_hsec = 0, tick_sec = 0, tick_min = 0, tick_hour = 0, tick_day = 0;
    logic [7:0] cnt_hsec = '0, cnt_sec = '0, cnt_min = '0, cnt_hour = '0;
    logic [7:0] cnt_ydate = '0, cnt_wdmon = '0;
    logic [7:0] alm_hsec = 8'h11, alm_sec = 8'h22, alm_min = 8'h33, alm_hour = 8'h04;
    logic [7:0] alm_ydate = 8'h15, alm_wdmon = 8'h06, alm_timer = 8'h55;
    logic flag_wr = 0;
    logic [1:0] flag_wdata = '0;
    logic timer_wr = 0;
    logic [7:0] timer_wdata = '0;
    logic [1:0] stat_flags;
    logic [7:0] timer_val;
    logic irq_drive_low;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_tmr = '0;
    logic m_tf = 0, m_af = 0, m_ws = 0, m_wm = 0, m_cprev = 1, m_tprev = 1, m_int = 0;

    always #2 clk = ~clk;

    rtc_alarm_unit u_rtc_alarm_unit (
        .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .alarm_ctl(alarm_ctl),
        .tick_hsec(tick_hsec), .tick_sec(tick_sec), .tick_min(tick_min),
        .tick_hour(tick_hour), .tick_day(tick_day),
        .cnt_hsec(cnt_hsec), .cnt_sec(cnt_sec), .cnt_min(cnt_min), .cnt_hour(cnt_hour),
        .cnt_ydate(cnt_ydate), .cnt_wdmon(cnt_wdmon),
        .alm_hsec(alm_hsec), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_ydate(alm_ydate), .alm_wdmon(alm_wdmon), .alm_timer(alm_timer),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .timer_wr(timer_wr),
        .timer_wdata(timer_wdata), .stat_flags(stat_flags), .timer_val(timer_val),
        .irq_drive_low(irq_drive_low)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ref_bcd(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // calendar match per R2, R8, R9
    function automatic logic ref_cal();
        logic t;
        t = (cnt_hsec == alm_hsec) && (cnt_sec == alm_sec) &&
            (cnt_min == alm_min) && (cnt_hour == alm_hour);
        case (alarm_ctl[5:4])
            2'b01: return t;
            2'b10: return t && (cnt_wdmon[7:5] != 3'd7) && alm_wdmon[cnt_wdmon[7:5]];
            2'b11: return t && (cnt_ydate[5:0] == alm_ydate[5:0]) &&
                          (cnt_wdmon[4:0] == alm_wdmon[4:0]);
            default: return 1'b0;
        endcase
    endfunction

    task automatic ref_step();
        logic en, adv, wrap, teq, st, sc, ceq;
        logic [7:0] t_old;
        en = alarm_en;
        t_old = m_tmr;
        wrap = 0;
        case (alarm_ctl[2:0])
            3'd1: adv = tick_hsec;
            3'd2: adv = tick_sec;
            3'd3: adv = tick_min;
            3'd4: adv = tick_hour;
            3'd5: adv = tick_day;
            3'd7: adv = 1'b1;
            default: adv = 1'b0;
        endcase
        adv = adv && en;
        if (timer_wr) m_tmr = timer_wdata;
        else if (adv) begin
            if (m_tmr == 8'h99) begin m_tmr = 8'h00; wrap = 1; end
            else m_tmr = ref_bcd(m_tmr);
        end
        teq = (t_old == alm_timer);
        st = en && alarm_ctl[6] && teq && !m_tprev;
        m_tprev = teq;
        sc = 0;
        if (tick_hsec) begin
            ceq = en && ref_cal();
            sc = ceq && !m_cprev;
            m_cprev = ceq;
            m_ws = (cnt_hsec >= 8'h50);
            m_wm = (cnt_sec >= 8'h30);
        end
        if (flag_wr) begin m_tf = flag_wdata[0]; m_af = flag_wdata[1]; end
        if (en && wrap) m_tf = 1;
        if (st || sc) m_af = 1;
        m_int = en ? ((m_af && alarm_ctl[7]) || (m_tf && alarm_ctl[3])) : m_ws;
    endtask

    // one clock with model update and full comparison
    task automatic step(input string tag);
        logic [1:0] es;
        ref_step();
        @(posedge clk);
        #1;
        es = alarm_en ? {m_af, m_tf} : {m_wm, m_ws};
        chk({tag, " stat"}, {6'd0, stat_flags}, {6'd0, es});
        chk({tag, " timer"}, timer_val, m_tmr);
        chk({tag, " irq"}, {7'd0, irq_drive_low}, {7'd0, m_int});
        tick_hsec = 0; tick_sec = 0; tick_min = 0; tick_hour = 0; tick_day = 0;
        flag_wr = 0; timer_wr = 0;
    endtask

    task automatic match_time();
        cnt_hsec = alm_hsec; cnt_sec = alm_sec; cnt_min = alm_min; cnt_hour = alm_hour;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 stat", {6'd0, stat_flags}, 8'h00);
        chk("R1 timer", timer_val, 8'h00);
        chk("R1 irq", {7'd0, irq_drive_low}, 8'h00);
        alarm_en = 1;

        // R3: seconds resolution, write then steps
        alarm_ctl = 8'h02;
        timer_wr = 1; timer_wdata = 8'h08; step("R3 load");
        tick_sec = 1; step("R3 sec step");
        tick_hsec = 1; step("R3 hsec ignored");
        tick_sec = 1; step("R3 sec step");
        chk("R3 value", timer_val, 8'h10);
        alarm_ctl = 8'h06; // 110 holds
        tick_sec = 1; tick_day = 1; step("R3 spare hold");
        chk("R3 spare", timer_val, 8'h10);
        alarm_ctl = 8'h07; step("R3 test"); step("R3 test");
        chk("R3 every cycle", timer_val, 8'h12);

        // R4 + R7: wrap sets timer flag and drives interrupt
        alarm_ctl = 8'h0A;
        timer_wr = 1; timer_wdata = 8'h98; step("R4 load");
        tick_sec = 1; step("R4 to 99");
        tick_sec = 1; step("R4 wrap");
        chk("R4 wrap value", timer_val, 8'h00);
        chk("R4 timer flag", {7'd0, stat_flags[0]}, 8'h01);
        chk("R7 irq on timer", {7'd0, irq_drive_low}, 8'h01);

        // R6: write clears; set beats write
        flag_wr = 1; flag_wdata = 2'b00; step("R6 clear");
        chk("R6 cleared", {6'd0, stat_flags}, 8'h00);
        alarm_ctl = 8'h07; timer_wr = 1; timer_wdata = 8'h99; step("R6 load");
        flag_wr = 1; flag_wdata = 2'b00; step("R6 set wins");
        chk("R6 set wins", {7'd0, stat_flags[0]}, 8'h01);
        flag_wr = 1; flag_wdata = 2'b00; alarm_ctl = 8'h00; step("R6 clear");

        // R5: timer match one edge late
        alarm_ctl = 8'hC2; alm_timer = 8'h02;
        timer_wr = 1; timer_wdata = 8'h01; step("R5 load");
        tick_sec = 1; step("R5 reach");
        chk("R5 not yet", {7'd0, stat_flags[1]}, 8'h00);
        step("R5 set");
        chk("R5 alarm flag", {7'd0, stat_flags[1]}, 8'h01);
        chk("R7 irq on alarm", {7'd0, irq_drive_low}, 8'h01);
        flag_wr = 1; flag_wdata = 2'b00; step("R6 clear");
        step("R10 held timer match");
        chk("R10 timer held", {7'd0, stat_flags[1]}, 8'h00);

        // R2 daily
        alarm_ctl = 8'h90; alm_timer = 8'h77;
        match_time(); cnt_wdmon = 8'hE9; cnt_ydate = 8'h3F;
        tick_hsec = 1; step("R2 daily");
        chk("R2 daily flag", {7'd0, stat_flags[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 2'b00; step("R6 clear");
        tick_hsec = 1; step("R10 held"); tick_hsec = 1; step("R10 held");
        chk("R10 no refire", {7'd0, stat_flags[1]}, 8'h00);

        // R8 weekday mask
        alarm_ctl = 8'h20; alm_wdmon = 8'b1000_0101;
        cnt_hsec = 8'h00; tick_hsec = 1; step("R8 break");
        match_time(); cnt_wdmon = {3'd1, 5'd3}; tick_hsec = 1; step("R8 masked day");
        chk("R8 masked", {7'd0, stat_flags[1]}, 8'h00);
        cnt_hsec = 8'h00; tick_hsec = 1; step("R8 break");
        match_time(); cnt_wdmon = {3'd2, 5'd3}; tick_hsec = 1; step("R8 enabled day");
        chk("R8 fires", {7'd0, stat_flags[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 2'b00; step("R6 clear");

        // R9 dated
        alarm_ctl = 8'h30; alm_ydate = 8'h15; alm_wdmon = 8'h06;
        cnt_hsec = 8'h00; tick_hsec = 1; step("R9 break");
        match_time(); cnt_ydate = 8'hD5; cnt_wdmon = {3'd5, 5'd7}; tick_hsec = 1;
        step("R9 month differs");
        chk("R9 month", {7'd0, stat_flags[1]}, 8'h00);
        cnt_wdmon = {3'd4, 5'd6}; tick_hsec = 1; step("R9 year ignored");
        chk("R9 fires", {7'd0, stat_flags[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 2'b00; step("R6 clear");

        // R11 disabled: square waves, timer stopped
        alarm_en = 0; alarm_ctl = 8'hFF;
        cnt_hsec = 8'h60; cnt_sec = 8'h10; tick_hsec = 1; tick_sec = 1; step("R11 waves");
        chk("R11 sec wave", {7'd0, stat_flags[0]}, 8'h01);
        chk("R11 irq wave", {7'd0, irq_drive_low}, 8'h01);
        chk("R11 min wave", {7'd0, stat_flags[1]}, 8'h00);
        chk("R11 timer held", timer_val, 8'h02);
        cnt_hsec = 8'h49; cnt_sec = 8'h45; tick_hsec = 1; step("R11 waves");
        chk("R11 min wave hi", {7'd0, stat_flags[1]}, 8'h01);
        chk("R11 irq low", {7'd0, irq_drive_low}, 8'h00);

        // random traffic checked against the model
        alm_hsec = 8'h25; alm_sec = 8'h30; alm_min = 8'h15; alm_hour = 8'h07;
        alm_ydate = 8'h12; alm_wdmon = 8'h45;
        for (int i = 0; i < 4000; i++) begin
            alarm_en = ($urandom % 8) != 0;
            if ($urandom % 32 == 0) alarm_ctl = 8'($urandom);
            alm_timer = {4'd0, 4'($urandom % 4)};
            cnt_hsec = ($urandom % 4 != 0) ? alm_hsec : 8'h60;
            cnt_sec  = ($urandom % 4 != 0) ? alm_sec  : 8'h29;
            cnt_min  = ($urandom % 8 != 0) ? alm_min  : 8'h16;
            cnt_hour = ($urandom % 8 != 0) ? alm_hour : 8'h08;
            cnt_ydate = {2'($urandom), ($urandom % 4 != 0) ? 6'h12 : 6'h13};
            cnt_wdmon = {3'($urandom), ($urandom % 4 != 0) ? 5'h05 : 5'h06};
            tick_hsec = ($urandom % 2) == 0;
            tick_sec = ($urandom % 4) == 0;
            tick_min = ($urandom % 8) == 0;
            tick_hour = ($urandom % 8) == 0;
            tick_day = ($urandom % 8) == 0;
            flag_wr = ($urandom % 16) == 0;
            flag_wdata = 2'($urandom);
            timer_wr = ($urandom % 64) == 0;
            timer_wdata = {4'($urandom % 10), 4'($urandom % 10)};
            step("R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule